// File: doc/BRIEF.md
# Instruction Fetch Micro Translation Cache

This block is a two-entry address translation cache that sits on the instruction fetch path only. Data accesses use the joint TLB directly, so instruction and data addresses can be translated in the same cycle. Each fetch address is compared against both entries at once. On a hit, the physical address is formed in the same cycle. The upper 20 bits come from the stored frame number and the low 12 bits are passed through unchanged, because every entry covers exactly one 4 KB page.

On a miss, the block holds fetch with a stall and sends a lookup request to the joint TLB. The request carries the fetch address and the current address-space tag. When the answer arrives, the returned frame and its cacheability flag are written into a free entry, or into the least recently used one if both are full. The stall then drops. An answer that reports a translation fault is not stored; it is handed back to the fetch unit as a one-cycle error.

Software changes to translation state are handled by invalidating everything. A flush pulse, or any change of the current address-space tag, clears both entries in the next cycle. A refill that is in flight when such a clear happens is thrown away rather than installed.

Top module: `ifetch_utlb`

## Requirements
- R1: After reset both entries are invalid, and fetch_hit, fetch_stall, fetch_err and jt_req are all low while no fetch is requested.
- R2: When fetch_req is high and a valid entry matches the fetch page (bits 31:12), the same cycle shows fetch_hit high, fetch_stall low, fetch_pa equal to the stored 20-bit frame followed by fetch address bits 11:0, and fetch_uncached equal to the stored uncached flag.
- R3: When fetch_req is high, no entry matches and the block is idle, fetch_stall is high in that cycle. In the next cycle jt_req rises, with jt_va equal to the fetch address and jt_asid equal to cur_asid. jt_req, jt_va and jt_asid hold steady through the cycle in which jt_rsp_valid is seen, and jt_req is low in the cycle after.
- R4: A response with jt_rsp_err low installs the page, the frame and the uncached flag. In the cycle after the response, the held fetch hits with fetch_stall low. Offset bits 11:0 are never translated.
- R5: A response with jt_rsp_err high installs nothing. fetch_err is then high for exactly the following cycle, and in that cycle fetch_stall is low and no new request is started.
- R6: A fill goes to the lowest-numbered invalid entry. If both entries are valid, it goes to the least recently used one. Both hits and fills make an entry the most recently used.
- R7: At most one entry matches any fetch address, so only one mapping drives fetch_pa.
- R8: A flush pulse invalidates both entries at the next clock edge.
- R9: A change of cur_asid from its value in the previous cycle invalidates both entries at the next clock edge.
- R10: If a flush or an address-space change occurs while a refill is outstanding, including in the response cycle itself, the response is discarded. The stall then continues and a fresh request is issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | A fetch address is presented this cycle |
| fetch_va | input | 32 | Virtual fetch address |
| cur_asid | input | 8 | Current address-space tag |
| flush | input | 1 | Invalidate all entries |
| fetch_hit | output | 1 | Fetch address translated this cycle |
| fetch_pa | output | 32 | Translated physical address (zero on miss) |
| fetch_uncached | output | 1 | Uncached flag of the hit entry |
| fetch_stall | output | 1 | Hold fetch, a refill is needed or pending |
| fetch_err | output | 1 | The joint TLB reported a fault for the refill |
| jt_req | output | 1 | Lookup request to the joint TLB |
| jt_va | output | 32 | Address carried by the request |
| jt_asid | output | 8 | Address-space tag carried by the request |
| jt_rsp_valid | input | 1 | Joint TLB answer present |
| jt_rsp_pfn | input | 20 | Returned physical frame number |
| jt_rsp_global | input | 1 | Returned global flag |
| jt_rsp_uncached | input | 1 | Returned uncached flag |
| jt_rsp_err | input | 1 | Lookup failed |

## Verification
Some properties are checked on every cycle by assertions: that hits never coincide, that a hit with no refill pending never stalls, that a request stays stable until it is answered, that a flush or tag change removes every hit in the next cycle, that a faulting answer is followed by a single error cycle with the entries untouched, and that a discarded refill leaves the cache empty. Other behaviours can only be shown by the bench's scenarios, which compare against a reference model. These are the choice of victim under the LRU rule, the exact frame and offset on fetch_pa, the cycle in which the stall releases after each response latency, and the reissue of a request after a discarded refill.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  // Address geometry: fixed 4 KB pages.
  localparam int VA_W    = 32;
  localparam int PG_W    = 12;
  localparam int VPN_W   = VA_W - PG_W;
  localparam int PFN_W   = 20;
  localparam int PA_W    = PFN_W + PG_W;
  localparam int ASID_W  = 8;
  // The single-bit recency tracker assumes exactly two entries.
  localparam int NUM_ENT = 2;
  localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              nc;
  } utlb_ent_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_ERR  = 2'd2
  } fill_st_e;
endpackage

// File: rtl/utlb_entry_bank.sv
module utlb_entry_bank
  import utlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  utlb_ent_t          wr_ent,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic [NUM_ENT-1:0] hit_vec,
  output logic [NUM_ENT-1:0] vld_vec,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_nc
);

  logic [NUM_ENT-1:0] vld_q, vld_d;
  utlb_ent_t          ent_q [NUM_ENT];

  // Valid bits: clear has priority over a write.
  always_comb begin
    vld_d = vld_q;
    if (clr_all) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Payload: no reset, written only under its own enable.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        ent_q[i] <= wr_ent;
      end
    end
  end

  // Parallel tag compare, one comparator per entry.
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic page_eq;
    logic space_ok;
    assign page_eq     = (ent_q[g].vpn == lk_vpn);
    assign space_ok    = ent_q[g].glob || (ent_q[g].asid == lk_asid);
    assign hit_vec[g]  = vld_q[g] && page_eq && space_ok;
  end

  assign vld_vec = vld_q;

  // AND-OR select; relies on at most one hit.
  always_comb begin
    hit_pfn = '0;
    hit_nc  = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hit_vec[i]) begin
        hit_pfn = hit_pfn | ent_q[i].pfn;
        hit_nc  = hit_nc | ent_q[i].nc;
        hit_idx = hit_idx | IDX_W'(i);
      end
    end
  end

  // R7: fills only follow misses, so two entries never match together.
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec))
    else $error("R7: more than one entry matched");

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim
  import utlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] vld_vec,
  input  logic               hit_any,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] lru_q, lru_d;

  // Lowest-numbered empty slot first, otherwise the older entry.
  always_comb begin
    victim_idx = lru_q;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!vld_vec[i]) begin
        victim_idx = IDX_W'(i);
      end
    end
  end

  // With two entries the least recent one is simply the other one.
  always_comb begin
    lru_d = lru_q;
    if (fill_en) begin
      lru_d = ~victim_idx;
    end else if (hit_any) begin
      lru_d = ~hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      lru_q <= lru_d;
    end
  end

  // R6: a hit entry must not be chosen for the fill in the next cycle.
  a_r6_hit_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_any && !fill_en && (&vld_vec)) |=> ((&vld_vec) ? (victim_idx != $past(hit_idx)) : 1'b1))
    else $error("R6: most recently hit entry selected as victim");

endmodule

// File: rtl/utlb_fill_ctrl.sv
module utlb_fill_ctrl
  import utlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              lk_miss,
  input  logic [VA_W-1:0]   fetch_va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              clr_req,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              jt_req,
  output logic [VA_W-1:0]   jt_va,
  output logic [ASID_W-1:0] jt_asid,
  output logic              install,
  output logic              stall,
  output logic              fetch_err
);

  fill_st_e          st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic              stale_q, stale_d;
  logic              cap_en;

  always_comb begin
    st_d    = st_q;
    stale_d = stale_q;
    cap_en  = 1'b0;
    install = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (fetch_req && lk_miss) begin
          st_d    = FS_WAIT;
          cap_en  = 1'b1;
          stale_d = 1'b0;
        end
      end
      FS_WAIT: begin
        stale_d = stale_q | clr_req;
        if (rsp_valid) begin
          st_d    = rsp_err ? FS_ERR : FS_IDLE;
          install = !rsp_err && !stale_q && !clr_req;
        end
      end
      FS_ERR:  st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stale_q <= stale_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      va_q   <= fetch_va;
      asid_q <= cur_asid;
    end
  end

  assign jt_req    = (st_q == FS_WAIT);
  assign jt_va     = va_q;
  assign jt_asid   = asid_q;
  assign fetch_err = (st_q == FS_ERR);
  assign stall     = (st_q == FS_WAIT) || ((st_q == FS_IDLE) && fetch_req && lk_miss);

  // R3: an unanswered request keeps its address and tag.
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (jt_req && !rsp_valid) |=> (jt_req && $stable(jt_va) && $stable(jt_asid)))
    else $error("R3: request dropped or changed before answer");

  // R5: a faulting answer gives one error cycle with no stall and no request.
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (jt_req && rsp_valid && rsp_err) |=> (fetch_err && !jt_req && !stall))
    else $error("R5: error not reported after faulting answer");

  a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |=> !fetch_err)
    else $error("R5: error lasted more than one cycle");

endmodule

// File: rtl/ifetch_utlb.sv
module ifetch_utlb
  import utlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [VA_W-1:0]   fetch_va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              flush,
  output logic              fetch_hit,
  output logic [PA_W-1:0]   fetch_pa,
  output logic              fetch_uncached,
  output logic              fetch_stall,
  output logic              fetch_err,
  output logic              jt_req,
  output logic [VA_W-1:0]   jt_va,
  output logic [ASID_W-1:0] jt_asid,
  input  logic              jt_rsp_valid,
  input  logic [PFN_W-1:0]  jt_rsp_pfn,
  input  logic              jt_rsp_global,
  input  logic              jt_rsp_uncached,
  input  logic              jt_rsp_err
);

  logic [ASID_W-1:0]  asid_prev_q;
  logic               clr_req;
  logic [NUM_ENT-1:0] hit_vec, vld_vec;
  logic [IDX_W-1:0]   hit_idx, victim_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_nc;
  logic               any_hit, lk_miss, install;
  utlb_ent_t          new_ent;

  // Tag-change detector feeding the global clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asid_prev_q <= '0;
    end else begin
      asid_prev_q <= cur_asid;
    end
  end

  assign clr_req = flush || (cur_asid != asid_prev_q);

  assign new_ent.vpn  = jt_va[VA_W-1:PG_W];
  assign new_ent.pfn  = jt_rsp_pfn;
  assign new_ent.asid = jt_asid;
  assign new_ent.glob = jt_rsp_global;
  assign new_ent.nc   = jt_rsp_uncached;

  utlb_entry_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_req),
    .wr_en   (install),
    .wr_idx  (victim_idx),
    .wr_ent  (new_ent),
    .lk_vpn  (fetch_va[VA_W-1:PG_W]),
    .lk_asid (cur_asid),
    .hit_vec (hit_vec),
    .vld_vec (vld_vec),
    .hit_idx (hit_idx),
    .hit_pfn (hit_pfn),
    .hit_nc  (hit_nc)
  );

  assign any_hit = fetch_req && (|hit_vec);
  assign lk_miss = !(|hit_vec);

  utlb_victim u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld_vec    (vld_vec),
    .hit_any    (any_hit),
    .hit_idx    (hit_idx),
    .fill_en    (install),
    .victim_idx (victim_idx)
  );

  utlb_fill_ctrl u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .lk_miss   (lk_miss),
    .fetch_va  (fetch_va),
    .cur_asid  (cur_asid),
    .clr_req   (clr_req),
    .rsp_valid (jt_rsp_valid),
    .rsp_err   (jt_rsp_err),
    .jt_req    (jt_req),
    .jt_va     (jt_va),
    .jt_asid   (jt_asid),
    .install   (install),
    .stall     (fetch_stall),
    .fetch_err (fetch_err)
  );

  assign fetch_hit      = any_hit;
  assign fetch_pa       = any_hit ? {hit_pfn, fetch_va[PG_W-1:0]} : '0;
  assign fetch_uncached = any_hit && hit_nc;

  // R2: a hit with nothing outstanding never stalls.
  a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hit && !jt_req) |-> !fetch_stall)
    else $error("R2: stall on a hit");

  // R8: after a flush nothing can hit.
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_vec == '0))
    else $error("R8: entry survived a flush");

  // R9: after a tag change nothing can hit.
  a_r9_asid_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_asid != asid_prev_q) |=> !fetch_hit)
    else $error("R9: hit right after a tag change");

  // R5: a faulting answer leaves the entries as they were.
  a_r5_no_install: assert property (@(posedge clk) disable iff (!rst_n)
    (jt_req && jt_rsp_valid && jt_rsp_err && !clr_req) |=> $stable(vld_vec))
    else $error("R5: entry changed after faulting answer");

  // R10: an answer that meets a clear is not stored.
  a_r10_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (jt_req && jt_rsp_valid && clr_req) |=> (vld_vec == '0))
    else $error("R10: stale refill installed");

endmodule

// File: tb/ifetch_utlb_tb_top.sv
`timescale 1ns/1ps
module ifetch_utlb_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req;
  logic [31:0] fetch_va;
  logic [7:0]  cur_asid;
  logic        flush;
  logic        fetch_hit;
  logic [31:0] fetch_pa;
  logic        fetch_uncached;
  logic        fetch_stall;
  logic        fetch_err;
  logic        jt_req;
  logic [31:0] jt_va;
  logic [7:0]  jt_asid;
  logic        jt_rsp_valid;
  logic [19:0] jt_rsp_pfn;
  logic        jt_rsp_global;
  logic        jt_rsp_uncached;
  logic        jt_rsp_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ifetch_utlb dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_req       (fetch_req),
    .fetch_va        (fetch_va),
    .cur_asid        (cur_asid),
    .flush           (flush),
    .fetch_hit       (fetch_hit),
    .fetch_pa        (fetch_pa),
    .fetch_uncached  (fetch_uncached),
    .fetch_stall     (fetch_stall),
    .fetch_err       (fetch_err),
    .jt_req          (jt_req),
    .jt_va           (jt_va),
    .jt_asid         (jt_asid),
    .jt_rsp_valid    (jt_rsp_valid),
    .jt_rsp_pfn      (jt_rsp_pfn),
    .jt_rsp_global   (jt_rsp_global),
    .jt_rsp_uncached (jt_rsp_uncached),
    .jt_rsp_err      (jt_rsp_err)
  );

  // Reference model of the two entries and the recency bit.
  logic        mv   [2];
  logic [19:0] mvpn [2];
  logic [19:0] mpfn [2];
  logic [7:0]  masd [2];
  logic        mg   [2];
  logic        mn   [2];
  logic        mlru;
  logic [7:0]  asid_now;

  function automatic logic [19:0] page_vpn(input int pg);
    return 20'h4A000 + 20'(pg) * 20'h00123;
  endfunction
  function automatic logic [19:0] page_pfn(input logic [19:0] v);
    return v ^ 20'h9C35E;
  endfunction

  function automatic int m_find(input logic [19:0] v, input logic [7:0] a);
    for (int i = 0; i < 2; i++) begin
      if (mv[i] && mvpn[i] == v && (mg[i] || masd[i] == a)) return i;
    end
    return -1;
  endfunction

  task automatic m_clear();
    mv[0] = 1'b0;
    mv[1] = 1'b0;
  endtask

  // R6: free slot with lowest index first, else least recent.
  task automatic m_install(input logic [19:0] v);
    int w;
    w = !mv[0] ? 0 : (!mv[1] ? 1 : int'(mlru));
    mv[w]   = 1'b1;
    mvpn[w] = v;
    mpfn[w] = page_pfn(v);
    masd[w] = asid_now;
    mg[w]   = v[1];
    mn[w]   = v[0];
    mlru    = (w == 0);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_rsp(input logic [19:0] v, input bit valid, input bit err);
    jt_rsp_valid    = valid;
    jt_rsp_pfn      = page_pfn(v);
    jt_rsp_global   = v[1];
    jt_rsp_uncached = v[0];
    jt_rsp_err      = err;
  endtask

  // One fetch, including a refill when the model predicts a miss.
  task automatic do_fetch(input int pg, input logic [11:0] ofs, input bit err,
                          input int lat, input bit clr_mid);
    logic [19:0] v;
    int e;
    v = page_vpn(pg);
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_va  = {v, ofs};
    #1;
    e = m_find(v, asid_now);
    if (e >= 0) begin
      chk("R2 hit", 32'(fetch_hit), 32'd1);
      chk("R2/R7 pa", fetch_pa, {mpfn[e], ofs});
      chk("R2 uncached", 32'(fetch_uncached), 32'(mn[e]));
      chk("R2 no stall", 32'(fetch_stall), 32'd0);
      mlru = (e == 0);
      return;
    end
    chk("R3 miss stall", 32'(fetch_stall), 32'd1);
    chk("R3 miss no hit", 32'(fetch_hit), 32'd0);
    chk("R3 no request yet", 32'(jt_req), 32'd0);
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      flush = clr_mid && (k == 0);
      drive_rsp(v, (k == lat), err);
      #1;
      chk("R3 request up", 32'(jt_req), 32'd1);
      chk("R3 request va", jt_va, {v, ofs});
      chk("R3 request asid", 32'(jt_asid), 32'(asid_now));
      chk("R3 stall held", 32'(fetch_stall), 32'd1);
      if (flush) m_clear();
    end
    @(negedge clk);
    flush = 1'b0;
    drive_rsp(v, 1'b0, 1'b0);
    #1;
    if (err) begin
      chk("R5 error flag", 32'(fetch_err), 32'd1);
      chk("R5 no stall", 32'(fetch_stall), 32'd0);
      chk("R5 no hit", 32'(fetch_hit), 32'd0);
      chk("R5 no request", 32'(jt_req), 32'd0);
      @(negedge clk);
      fetch_req = 1'b0;
      #1;
      chk("R5 error single", 32'(fetch_err), 32'd0);
      chk("R5 still no request", 32'(jt_req), 32'd0);
    end else if (clr_mid) begin
      chk("R10 discarded no hit", 32'(fetch_hit), 32'd0);
      chk("R10 stall continues", 32'(fetch_stall), 32'd1);
      chk("R3 request dropped", 32'(jt_req), 32'd0);
      @(negedge clk);
      drive_rsp(v, 1'b1, 1'b0);
      #1;
      chk("R10 request reissued", 32'(jt_req), 32'd1);
      @(negedge clk);
      drive_rsp(v, 1'b0, 1'b0);
      #1;
      m_install(v);
      chk("R10 hit after reissue", 32'(fetch_hit), 32'd1);
      chk("R10 pa", fetch_pa, {page_pfn(v), ofs});
    end else begin
      m_install(v);
      chk("R4 hit after fill", 32'(fetch_hit), 32'd1);
      chk("R4 pa", fetch_pa, {page_pfn(v), ofs});
      chk("R4 uncached", 32'(fetch_uncached), 32'(v[0]));
      chk("R4 stall released", 32'(fetch_stall), 32'd0);
      chk("R3 request ended", 32'(jt_req), 32'd0);
    end
  endtask

  task automatic probe_empty(input string tag);
    fetch_req = 1'b1;
    fetch_va  = {page_vpn(0), 12'h0};
    #1;
    chk(tag, 32'(fetch_hit), 32'd0);
    fetch_req = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    fetch_req = 1'b0;
    flush     = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_clear();
    probe_empty("R8 empty after flush");
  endtask

  task automatic set_asid(input logic [7:0] a);
    bit changed;
    changed = (a != asid_now);
    @(negedge clk);
    fetch_req = 1'b0;
    cur_asid  = a;
    asid_now  = a;
    @(negedge clk);
    if (changed) begin
      m_clear();
      probe_empty("R9 empty after tag change");
    end
  endtask

  initial begin
    void'($urandom(32'd7351));
    rst_n = 1'b0;
    fetch_req = 1'b0;
    fetch_va = '0;
    cur_asid = 8'h00;
    asid_now = 8'h00;
    flush = 1'b0;
    drive_rsp(20'h0, 1'b0, 1'b0);
    mlru = 1'b0;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 hit low", 32'(fetch_hit), 32'd0);
    chk("R1 stall low", 32'(fetch_stall), 32'd0);
    chk("R1 error low", 32'(fetch_err), 32'd0);
    chk("R1 request low", 32'(jt_req), 32'd0);
    probe_empty("R1 empty after reset");

    // Directed: fills, hits, R6 replacement order, faults, clears.
    do_fetch(0, 12'h123, 1'b0, 2, 1'b0);
    do_fetch(0, 12'hFFC, 1'b0, 0, 1'b0);
    do_fetch(1, 12'h004, 1'b0, 0, 1'b0);
    do_fetch(0, 12'h010, 1'b0, 0, 1'b0);
    do_fetch(2, 12'h020, 1'b0, 1, 1'b0);   // R6 evicts page 1
    do_fetch(1, 12'h030, 1'b0, 3, 1'b0);   // R6 evicts page 0
    do_fetch(2, 12'h040, 1'b0, 0, 1'b0);
    do_fetch(3, 12'h050, 1'b1, 1, 1'b0);   // R5 fault
    do_fetch(3, 12'h050, 1'b0, 0, 1'b0);
    do_flush();
    do_fetch(0, 12'h060, 1'b0, 2, 1'b1);   // R10 clear while waiting
    do_fetch(4, 12'h070, 1'b0, 0, 1'b1);   // R10 clear in answer cycle
    set_asid(8'h05);
    do_fetch(4, 12'h080, 1'b0, 1, 1'b0);

    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 16) begin
        do_fetch(int'($urandom % 5), 12'($urandom), ($urandom % 10) == 0,
                 int'($urandom % 4), ($urandom % 12) == 0);
      end else if (r < 18) begin
        do_flush();
      end else begin
        set_asid(8'($urandom % 3));
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule